// File: doc/BRIEF.md
# Nonce Search Controller with Bus Register File

This block is the control side of a hashing engine. A host on a Wishbone bus writes a difficulty target, a set of message words and an enable bit into a 23-word register file. The hashing core runs on its own programmable clock and is not part of the block. In the hash clock domain the block holds a nonce counter that it presents to the core every cycle. The core answers with a digest prefix, and the block compares that prefix against the target.

When a digest qualifies, the counter stops on the winning nonce. That value travels back to the bus clock through a request/acknowledge handshake and is posted in a status word. The host then clears the result, and the search carries on from the following nonce.

Signals between the clocks take one of three paths. Single-bit controls and status pass through two-flop synchronizers. The frozen nonce is sampled only while the handshake guarantees it is stable. The target and message words are copied into the hash domain on the synchronized rising edge of enable, when the host has stopped changing them.

Top module: `mining_ctrl_regs`

## Requirements
- R1: After reset every register word reads zero, `nonce_o` is zero, `msg_o` is zero and `wb_ack_o` is low.
- R2: A strobe with `wb_cyc_i` high is acknowledged one bus cycle later. The acknowledge lasts exactly one cycle, and each strobe gets exactly one acknowledge.
- R3: The following words read back what was last written: target (word 3, full 32 bits), message words (words 4 to 22) and the enable bit (word 0, bit 0).
- R4: Writes to status (word 1) and found nonce (word 2) have no effect. Addresses 23 to 31 read zero and ignore writes.
- R5: While enabled and not frozen, `nonce_o` increases by exactly one per hash clock. While disabled it holds its value. It starts from zero after reset.
- R6: A nonce qualifies when `digest_i`, taken as unsigned, is less than or equal to the loaded target. On the first qualifying nonce the counter freezes, and `nonce_o` holds that nonce.
- R7: After a qualifying nonce, status bit 0 (found) reads 1 and word 2 reads the winning nonce. Because every nonce is tested once and in order, this is the first qualifying value after the search start.
- R8: Writing 1 to word 0 bit 1 while found is set clears found and resumes the search at winning nonce plus one. This bit always reads as 0.
- R9: Status bit 1 (running) reads 1 while enabled and not frozen. It reads 0 while frozen or disabled.
- R10: The target and message words take effect in the hash domain only on a rising edge of enable, and `msg_o` shows the copy loaded then. Writes made while enabled do not change the search or `msg_o` until the next rising edge of enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| hclk_i | input | 1 | Hash clock, independent of the bus clock |
| rst_ni | input | 1 | Active-low asynchronous reset, both domains |
| wb_cyc_i | input | 1 | Bus cycle valid |
| wb_stb_i | input | 1 | Bus strobe |
| wb_we_i | input | 1 | Write enable |
| wb_adr_i | input | AW (5) | Word address |
| wb_dat_i | input | DW (32) | Write data |
| wb_dat_o | output | DW (32) | Read data, valid with acknowledge |
| wb_ack_o | output | 1 | Acknowledge |
| digest_i | input | DIFF_W (32) | Leading digest bits from the core for the current `nonce_o` |
| nonce_o | output | NONCE_W (32) | Nonce presented to the core (hash domain) |
| msg_o | output | 19*DW (608) | Message words loaded into the hash domain, word 4 in the low bits |

## Verification
The bench models the core as a mixing function of the nonce. It predicts each winning nonce by scanning forward from the point where the search restarts, so a design that skipped or retested a nonce, or resumed at the winner instead of the next value, would post a different number. It changes the target and the message words while mining is enabled. A design that passed them straight into the hash domain would find a hit too early or show new words on `msg_o`. It also changes the target and clears the result in the same disable/enable sequence, where a lost clear or a stale target shows up as a wrong or missing find. Writes to read-only and unused words, and the clear bit read-back, catch decode that leaks a write or reports a non-zero value.

// File: rtl/mrf_pkg.sv
`timescale 1ns/1ps
package mrf_pkg;
  localparam int REG_WORDS = 23;
  localparam int ADR_CTRL  = 0;
  localparam int ADR_STAT  = 1;
  localparam int ADR_NONCE = 2;
  localparam int ADR_TGT   = 3;
  localparam int MSG_BASE  = 4;
  localparam int MSG_WORDS = REG_WORDS - MSG_BASE;

  localparam int CTRL_EN    = 0;
  localparam int CTRL_CLR   = 1;
  localparam int STAT_FOUND = 0;
  localparam int STAT_RUN   = 1;
endpackage

// File: rtl/mrf_sync.sv
`timescale 1ns/1ps
module mrf_sync #(
  parameter int W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      q_o    <= '0;
    end else begin
      meta_q <= d_i;
      q_o    <= meta_q;
    end
  end
endmodule

// File: rtl/mrf_bus_regs.sv
`timescale 1ns/1ps
module mrf_bus_regs
  import mrf_pkg::*;
#(
  parameter int AW      = 5,
  parameter int DW      = 32,
  parameter int NONCE_W = 32,
  parameter int DIFF_W  = 32
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          cyc_i,
  input  logic                          stb_i,
  input  logic                          we_i,
  input  logic [AW-1:0]                 adr_i,
  input  logic [DW-1:0]                 dat_i,
  output logic [DW-1:0]                 dat_o,
  output logic                          ack_o,
  input  logic                          req_s_i,
  input  logic                          run_s_i,
  input  logic [NONCE_W-1:0]            nonce_h_i,
  output logic                          en_o,
  output logic                          clr_o,
  output logic [DIFF_W-1:0]             tgt_o,
  output logic [MSG_WORDS-1:0][DW-1:0]  msg_o,
  output logic                          found_o,
  output logic [NONCE_W-1:0]            fnonce_o
);
  logic               ack_q;
  logic [DW-1:0]      dat_q;
  logic               en_q;
  logic               clr_q;
  logic               found_q;
  logic               req_d_q;
  logic [DIFF_W-1:0]  tgt_q;
  logic [NONCE_W-1:0] fnonce_q;
  logic [DW-1:0]      msg_q [MSG_WORDS];
  logic [DW-1:0]      rdata;

  logic access, wr_en, rd_en;
  assign access = cyc_i & stb_i & ~ack_q;
  assign wr_en  = access & we_i;
  assign rd_en  = access & ~we_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ack_q <= 1'b0;
      dat_q <= '0;
    end else begin
      ack_q <= access;
      if (rd_en) dat_q <= rdata;
    end
  end

  // control, target and found-nonce handshake
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q     <= 1'b0;
      clr_q    <= 1'b0;
      found_q  <= 1'b0;
      req_d_q  <= 1'b0;
      tgt_q    <= '0;
      fnonce_q <= '0;
    end else begin
      req_d_q <= req_s_i;
      // req held high by hash side keeps the nonce frozen while sampled
      if (req_s_i && !req_d_q) begin
        found_q  <= 1'b1;
        fnonce_q <= nonce_h_i;
      end
      // four-phase: drop ack once the request has gone low
      if (clr_q && !req_s_i) begin
        clr_q   <= 1'b0;
        found_q <= 1'b0;
      end
      if (wr_en && adr_i == AW'(ADR_CTRL)) begin
        en_q <= dat_i[CTRL_EN];
        if (dat_i[CTRL_CLR] && found_q && !clr_q) clr_q <= 1'b1;
      end
      if (wr_en && adr_i == AW'(ADR_TGT)) tgt_q <= dat_i[DIFF_W-1:0];
    end
  end

  for (genvar g = 0; g < MSG_WORDS; g++) begin : g_msg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) msg_q[g] <= '0;
      else if (wr_en && adr_i == AW'(MSG_BASE + g)) msg_q[g] <= dat_i;
    end
    assign msg_o[g] = msg_q[g];
  end

  always_comb begin
    rdata = '0;
    if (adr_i == AW'(ADR_CTRL)) rdata[CTRL_EN] = en_q;
    if (adr_i == AW'(ADR_STAT)) begin
      rdata[STAT_FOUND] = found_q;
      rdata[STAT_RUN]   = run_s_i;
    end
    if (adr_i == AW'(ADR_NONCE)) rdata = DW'(fnonce_q);
    if (adr_i == AW'(ADR_TGT))   rdata = DW'(tgt_q);
    for (int i = 0; i < MSG_WORDS; i++) begin
      if (adr_i == AW'(MSG_BASE + i)) rdata = msg_q[i];
    end
  end

  assign dat_o    = dat_q;
  assign ack_o    = ack_q;
  assign en_o     = en_q;
  assign clr_o    = clr_q;
  assign tgt_o    = tgt_q;
  assign found_o  = found_q;
  assign fnonce_o = fnonce_q;
endmodule

// File: rtl/mrf_nonce_engine.sv
`timescale 1ns/1ps
module mrf_nonce_engine
  import mrf_pkg::*;
#(
  parameter int DW      = 32,
  parameter int NONCE_W = 32,
  parameter int DIFF_W  = 32
) (
  input  logic                          hclk_i,
  input  logic                          rst_ni,
  input  logic                          en_i,
  input  logic                          clr_i,
  input  logic [DIFF_W-1:0]             tgt_i,
  input  logic [MSG_WORDS-1:0][DW-1:0]  msg_i,
  input  logic [DIFF_W-1:0]             digest_i,
  output logic [NONCE_W-1:0]            nonce_o,
  output logic                          req_o,
  output logic                          run_o,
  output logic [MSG_WORDS-1:0][DW-1:0]  msg_o
);
  logic               en_d_q;
  logic [DIFF_W-1:0]  tgt_h_q;
  logic [NONCE_W-1:0] nonce_q;
  logic               req_q;
  logic               run_q;
  logic [DW-1:0]      msg_h_q [MSG_WORDS];

  logic load, running, hit;
  // config is quasi-static: sampled only once enable has crossed
  assign load    = en_i & ~en_d_q;
  assign running = en_d_q & ~req_q & ~clr_i;
  assign hit     = digest_i <= tgt_h_q;

  always_ff @(posedge hclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_d_q  <= 1'b0;
      tgt_h_q <= '0;
      nonce_q <= '0;
      req_q   <= 1'b0;
      run_q   <= 1'b0;
    end else begin
      en_d_q <= en_i;
      run_q  <= running;
      if (load) tgt_h_q <= tgt_i;
      if (req_q && clr_i) begin
        req_q   <= 1'b0;
        nonce_q <= nonce_q + 1'b1;
      end else if (running) begin
        if (hit) req_q   <= 1'b1;
        else     nonce_q <= nonce_q + 1'b1;
      end
    end
  end

  for (genvar g = 0; g < MSG_WORDS; g++) begin : g_shadow
    always_ff @(posedge hclk_i or negedge rst_ni) begin
      if (!rst_ni)   msg_h_q[g] <= '0;
      else if (load) msg_h_q[g] <= msg_i[g];
    end
    assign msg_o[g] = msg_h_q[g];
  end

  assign nonce_o = nonce_q;
  assign req_o   = req_q;
  assign run_o   = run_q;
endmodule

// File: rtl/mining_ctrl_regs.sv
`timescale 1ns/1ps
module mining_ctrl_regs
  import mrf_pkg::*;
#(
  parameter int AW      = 5,
  parameter int DW      = 32,
  parameter int NONCE_W = 32,
  parameter int DIFF_W  = 32,
  localparam int MSG_W  = MSG_WORDS * DW
) (
  input  logic               clk_i,
  input  logic               hclk_i,
  input  logic               rst_ni,
  input  logic               wb_cyc_i,
  input  logic               wb_stb_i,
  input  logic               wb_we_i,
  input  logic [AW-1:0]      wb_adr_i,
  input  logic [DW-1:0]      wb_dat_i,
  output logic [DW-1:0]      wb_dat_o,
  output logic               wb_ack_o,
  input  logic [DIFF_W-1:0]  digest_i,
  output logic [NONCE_W-1:0] nonce_o,
  output logic [MSG_W-1:0]   msg_o
);
  logic                         en_b, clr_b, found_b;
  logic [DIFF_W-1:0]            tgt_b;
  logic [NONCE_W-1:0]           fnonce_b;
  logic [MSG_WORDS-1:0][DW-1:0] msg_b, msg_h;
  logic                         en_h, clr_h, req_h, run_h;
  logic                         req_b, run_b;

  mrf_bus_regs #(
    .AW(AW), .DW(DW), .NONCE_W(NONCE_W), .DIFF_W(DIFF_W)
  ) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cyc_i     (wb_cyc_i),
    .stb_i     (wb_stb_i),
    .we_i      (wb_we_i),
    .adr_i     (wb_adr_i),
    .dat_i     (wb_dat_i),
    .dat_o     (wb_dat_o),
    .ack_o     (wb_ack_o),
    .req_s_i   (req_b),
    .run_s_i   (run_b),
    .nonce_h_i (nonce_o),
    .en_o      (en_b),
    .clr_o     (clr_b),
    .tgt_o     (tgt_b),
    .msg_o     (msg_b),
    .found_o   (found_b),
    .fnonce_o  (fnonce_b)
  );

  mrf_sync #(.W(2)) u_sync_to_hash (
    .clk_i  (hclk_i),
    .rst_ni (rst_ni),
    .d_i    ({en_b, clr_b}),
    .q_o    ({en_h, clr_h})
  );

  mrf_sync #(.W(2)) u_sync_to_bus (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({req_h, run_h}),
    .q_o    ({req_b, run_b})
  );

  mrf_nonce_engine #(
    .DW(DW), .NONCE_W(NONCE_W), .DIFF_W(DIFF_W)
  ) u_engine (
    .hclk_i   (hclk_i),
    .rst_ni   (rst_ni),
    .en_i     (en_h),
    .clr_i    (clr_h),
    .tgt_i    (tgt_b),
    .msg_i    (msg_b),
    .digest_i (digest_i),
    .nonce_o  (nonce_o),
    .req_o    (req_h),
    .run_o    (run_h),
    .msg_o    (msg_h)
  );

  assign msg_o = msg_h;
endmodule

module mining_ctrl_regs_chk
  import mrf_pkg::*;
#(
  parameter int AW      = 5,
  parameter int DW      = 32,
  parameter int NONCE_W = 32
) (
  input logic               clk_i,
  input logic               hclk_i,
  input logic               rst_ni,
  input logic               wb_cyc_i,
  input logic               wb_stb_i,
  input logic               wb_we_i,
  input logic [AW-1:0]      wb_adr_i,
  input logic [DW-1:0]      wb_dat_o,
  input logic               wb_ack_o,
  input logic [NONCE_W-1:0] nonce_o,
  input logic               req_h,
  input logic               found_b,
  input logic               clr_b,
  input logic [NONCE_W-1:0] fnonce_b
);
  a_r2_ack_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_ack_o |=> !wb_ack_o);

  a_r2_ack_needs_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_ack_o |-> $past(wb_cyc_i && wb_stb_i));

  a_r4_unused_read_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wb_ack_o && $past(!wb_we_i && wb_adr_i >= AW'(REG_WORDS))) |-> wb_dat_o == '0);

  a_r5_step_by_one: assert property (@(posedge hclk_i) disable iff (!rst_ni)
    !$stable(nonce_o) |-> nonce_o == $past(nonce_o) + 1'b1);

  a_r6_frozen_holds: assert property (@(posedge hclk_i) disable iff (!rst_ni)
    (req_h && $past(req_h)) |-> $stable(nonce_o));

  a_r7_posted_is_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (found_b && !clr_b) |-> fnonce_b == nonce_o);
endmodule

bind mining_ctrl_regs mining_ctrl_regs_chk #(
  .AW(AW), .DW(DW), .NONCE_W(NONCE_W)
) u_chk (
  .clk_i    (clk_i),
  .hclk_i   (hclk_i),
  .rst_ni   (rst_ni),
  .wb_cyc_i (wb_cyc_i),
  .wb_stb_i (wb_stb_i),
  .wb_we_i  (wb_we_i),
  .wb_adr_i (wb_adr_i),
  .wb_dat_o (wb_dat_o),
  .wb_ack_o (wb_ack_o),
  .nonce_o  (nonce_o),
  .req_h    (req_h),
  .found_b  (found_b),
  .clr_b    (clr_b),
  .fnonce_b (fnonce_b)
);

// File: tb/tb_mining_ctrl_regs.sv
`timescale 1ns/1ps
module tb_mining_ctrl_regs;
  localparam int AW = 5;
  localparam int DW = 32;
  localparam int NW = 32;
  localparam int MW = 19;

  logic clk = 1'b0, hclk = 1'b0, rst_n = 1'b0;
  always #5   clk  = ~clk;
  always #3.5 hclk = ~hclk;

  logic          cyc = 0, stb = 0, we = 0;
  logic [AW-1:0] adr = '0;
  logic [DW-1:0] wdat = '0, rdat;
  logic          ack;
  logic [31:0]   digest;
  logic [NW-1:0] nonce;
  logic [MW*DW-1:0] msg;

  function automatic logic [31:0] mix(input logic [31:0] n);
    logic [31:0] h;
    h = (n ^ 32'h5bd1e995) * 32'h9e3779b1;
    h = h ^ (h >> 15);
    h = h * 32'h85ebca6b;
    h = h ^ (h >> 13);
    return h;
  endfunction

  assign digest = mix(nonce);

  mining_ctrl_regs dut (
    .clk_i(clk), .hclk_i(hclk), .rst_ni(rst_n),
    .wb_cyc_i(cyc), .wb_stb_i(stb), .wb_we_i(we), .wb_adr_i(adr),
    .wb_dat_i(wdat), .wb_dat_o(rdat), .wb_ack_o(ack),
    .digest_i(digest), .nonce_o(nonce), .msg_o(msg)
  );

  int n_run = 0, n_fail = 0, ack_err = 0;
  int unsigned exp_q[$];
  logic [31:0] last_found = '0;
  bit have_last = 0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wb_xfer(input bit w, input int a, input logic [31:0] d, output logic [31:0] r);
    int lat = 0;
    @(negedge clk);
    cyc = 1; stb = 1; we = w; adr = AW'(a); wdat = d;
    do begin @(negedge clk); lat++; end while (!ack && lat < 20);
    r = rdat;
    if (lat != 1) ack_err++;
    cyc = 0; stb = 0; we = 0;
    @(negedge clk);
    if (ack) ack_err++;
  endtask

  task automatic wb_wr(input int a, input logic [31:0] d);
    logic [31:0] dummy;
    wb_xfer(1'b1, a, d, dummy);
  endtask

  task automatic wb_rd(input int a, output logic [31:0] r);
    wb_xfer(1'b0, a, '0, r);
  endtask

  function automatic int unsigned scan(input int unsigned start, input logic [31:0] tgt);
    for (int unsigned n = start; n < start + 32'd200000; n++)
      if (mix(n) <= tgt) return n;
    return 32'hffff_ffff;
  endfunction

  // driver side of the scoreboard
  task automatic push_expect(input int unsigned start, input logic [31:0] tgt);
    exp_q.push_back(scan(start, tgt));
  endtask

  // monitor side: wait for a newly posted find, then compare with the queue head
  task automatic pop_found(input string tag);
    logic [31:0] s, n;
    int unsigned e;
    bit got = 0;
    e = exp_q.pop_front();
    for (int i = 0; i < 3000 && !got; i++) begin
      wb_rd(1, s);
      if (s[0]) begin
        wb_rd(2, n);
        if (!have_last || n != last_found) got = 1;
      end
    end
    chk(got && n == e, tag, n, e);
    last_found = n;
    have_last = 1;
  endtask

  initial begin
    #1_000_000;
    n_run++; n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  localparam logic [31:0] T1 = 32'h0400_0000;
  localparam logic [31:0] T2 = 32'h1000_0000;

  initial begin
    logic [31:0] r;
    logic [31:0] a, b;
    bit ok;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1: reset state
    chk(nonce == 0 && !ack, "R1 nonce/ack after reset", {nonce, 31'b0, ack}, 0);
    chk(msg == '0, "R1 msg_o after reset", msg[31:0], 0);
    ok = 1;
    for (int i = 0; i < 23; i++) begin
      wb_rd(i, r);
      if (r != 0) ok = 0;
    end
    chk(ok, "R1 register words after reset", ok, 1);

    // R3: read back of writable words
    wb_wr(3, T1);
    wb_rd(3, r);
    chk(r == T1, "R3 target read back", r, T1);
    for (int i = 4; i < 23; i++) wb_wr(i, 32'ha500_0000 + i);
    ok = 1;
    for (int i = 4; i < 23; i++) begin
      wb_rd(i, r);
      if (r != 32'ha500_0000 + i) ok = 0;
    end
    chk(ok, "R3 message words read back", ok, 1);

    // R4: read-only and unused addresses
    wb_wr(1, 32'hffff_ffff);
    wb_rd(1, r);
    chk(r == 0, "R4 status ignores write", r, 0);
    wb_wr(2, 32'h1234_5678);
    wb_rd(2, r);
    chk(r == 0, "R4 nonce word ignores write", r, 0);
    wb_wr(23, 32'hdead_beef);
    wb_wr(31, 32'hdead_beef);
    wb_rd(23, r);
    chk(r == 0, "R4 address 23 reads zero", r, 0);
    wb_rd(31, r);
    chk(r == 0, "R4 address 31 reads zero", r, 0);

    // R5: disabled counter stays at zero
    repeat (20) @(negedge hclk);
    chk(nonce == 0, "R5 idle nonce holds zero", nonce, 0);

    // target 0 first: search runs without a hit
    wb_wr(3, 32'h0);
    wb_wr(0, 32'h1);
    wb_rd(0, r);
    chk(r == 1, "R3 enable bit read back", r, 1);
    repeat (10) @(negedge clk);
    wb_rd(1, r);
    chk(r == 2, "R9 running while enabled", r, 2);
    @(negedge hclk);
    a = nonce;
    repeat (50) @(negedge hclk);
    b = nonce;
    chk(b - a == 50, "R5 one step per hash clock", b - a, 50);
    chk(msg[31:0] == 32'ha500_0004 && msg[MW*DW-1 -: 32] == 32'ha500_0016,
        "R10 msg_o loaded on enable", msg[31:0], 32'ha500_0004);

    // R10: writes while enabled have no effect until re-enable
    wb_wr(3, T1);
    wb_wr(4, 32'h0bad_0bad);
    repeat (300) @(negedge clk);
    wb_rd(1, r);
    chk(r == 2, "R10 target change not applied while enabled", r, 2);
    chk(msg[31:0] == 32'ha500_0004, "R10 msg_o unchanged while enabled", msg[31:0], 32'ha500_0004);

    // disable: counter holds
    wb_wr(0, 32'h0);
    repeat (10) @(negedge hclk);
    a = nonce;
    repeat (40) @(negedge hclk);
    chk(nonce == a, "R5 disabled nonce holds", nonce, a);
    wb_rd(1, r);
    chk(r == 0, "R9 not running when disabled", r, 0);

    // R6/R7: first find with target T1
    push_expect(a, T1);
    wb_wr(0, 32'h1);
    pop_found("R7 first found nonce");
    repeat (10) @(negedge hclk);
    chk(nonce == last_found, "R6 counter frozen on winner", nonce, last_found);
    chk(msg[31:0] == 32'h0bad_0bad, "R10 msg_o updated on re-enable", msg[31:0], 32'h0bad_0bad);
    repeat (10) @(negedge clk);
    wb_rd(1, r);
    chk(r == 1, "R9 found and not running", r, 1);

    // R8: clear and resume, several rounds
    for (int k = 0; k < 3; k++) begin
      push_expect(last_found + 1, T1);
      wb_wr(0, 32'h3);
      wb_rd(0, r);
      chk(r == 1, "R8 clear bit reads zero", r, 1);
      pop_found("R8 resume from next nonce");
    end

    // clear combined with a new target across disable/enable
    wb_wr(0, 32'h0);
    wb_wr(3, T2);
    push_expect(last_found + 1, T2);
    wb_wr(0, 32'h3);
    pop_found("R10 R8 new target after clear");
    chk(mix(last_found) <= T2, "R6 winner meets target", mix(last_found), T2);

    chk(ack_err == 0, "R2 ack latency and width", ack_err, 0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule